// File: doc/BRIEF.md
# External Clock Integrity Monitor with Safe-Clock Failover

This block watches an externally supplied clock from the domain of a free-running internal reference clock. It brings the external clock through a two-stage synchroniser, detects each rising edge, and measures the spacing between consecutive rising edges in reference ticks with a saturating counter. Three kinds of fault are recognised. An edge that comes sooner than the programmed minimum period is an early edge, which is the signature of a single injected clock glitch. A spacing longer than the programmed maximum is an out-of-range slow clock. A clock that stops producing edges for longer than a timeout counts as lost.

After enable, checking is held off until a programmable number of consecutive in-range intervals has been seen, so that start-up behaviour of the external source is not reported. Once armed, the first fault sets a sticky fault flag and a 2-bit cause. It also issues a one-cycle reset request and drives the clock-select output towards the internal safe source. These stay set until a software acknowledge or a power-on reset, so the system fails closed. The glitch-free clock multiplexer that acts on the select output is outside this block.

Top module: `clk_guard`

## Requirements
- R1: An armed monitor that measures a rising-edge interval strictly shorter than `min_period` sets `fault` and reports cause 2'b01 (early edge).
- R2: An armed monitor that measures an interval strictly longer than `max_period` sets `fault` with cause 2'b10 (slow). Intervals equal to `min_period` or equal to `max_period` are accepted without a fault.
- R3: When no rising edge is seen for `timeout` reference ticks, an armed monitor sets `fault` with cause 2'b11 (lost). A `timeout` of zero selects four times `max_period`.
- R4: `use_internal` goes to 1 in the same cycle that `fault` goes to 1. While no fault is held, `cause` reads 2'b00 and `use_internal` reads 0.
- R5: `reset_req` is a single-cycle pulse, issued exactly once for each transition of `fault` from 0 to 1.
- R6: `fault`, `cause` and `use_internal` hold their values until `ack` or `rst`. A one-cycle `ack` clears all three and restarts qualification.
- R7: After enable or ack, no fault is reported until `qual_count` consecutive in-range intervals have been measured. Any out-of-range interval restarts that count.
- R8: While a fault is held, further faults of any kind do not change `cause` and issue no further `reset_req`.
- R9: While `enable` is 0, no fault is detected, and a fault already held stays set.
- R10: After `rst`, `fault`, `cause`, `reset_req` and `use_internal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running internal reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_clk | input | 1 | External clock under watch (asynchronous) |
| enable | input | 1 | Monitoring enable; low clears measurement and qualification |
| min_period | input | W | Shortest accepted rising-edge interval, in reference ticks |
| max_period | input | W | Longest accepted rising-edge interval, in reference ticks |
| timeout | input | W | Ticks without an edge before loss; 0 selects 4 x max_period |
| qual_count | input | QW | Consecutive good intervals required before checking starts |
| ack | input | 1 | Software acknowledge; clears the held fault |
| fault | output | 1 | Sticky fault flag |
| cause | output | 2 | 00 none, 01 early edge, 10 slow, 11 lost |
| reset_req | output | 1 | One-cycle reset request on a new fault |
| use_internal | output | 1 | Clock selection: 1 selects the internal safe source |

## Verification
The bench builds the block with W = 10 and QW = 4. The 12-bit interval counter then covers the default timeout of four times any programmable maximum, and a qualification count of up to 15 can be exercised in a few hundred cycles. The external clock is driven on reference-clock falling edges, so every measured interval is an exact tick count. This makes the off-by-one limits at `min_period` and `max_period` and the timeout window directly reachable, together with random limit and gap combinations compared against a bench classification function.

// File: rtl/cgm_pkg.sv
package cgm_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_EARLY = 2'b01,
    CAUSE_SLOW  = 2'b10,
    CAUSE_LOST  = 2'b11
  } cause_e;
endpackage

// File: rtl/cgm_sync.sv
// Brings the external clock into the reference domain and flags each rising edge
module cgm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last   <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last   <= chain[STAGES-1];
      rise_o <= chain[STAGES-1] & ~last;
    end
  end

  // an edge flag never lasts two cycles in a row (feeds R1 interval timing)
  p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cgm_meter.sv
// Saturating count of reference ticks since the last synchronised rising edge
module cgm_meter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clr,
  input  logic          rise,
  output logic [CW-1:0] cnt,
  output logic          seen
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !en || clr) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (rise) begin
      cnt  <= {{(CW-1){1'b0}}, 1'b1};
      seen <= 1'b1;
    end else if (cnt != SAT) begin
      cnt  <= cnt + 1'b1;
    end
  end

  // counter never wraps from saturation back to a small value (R3)
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !rise && cnt == SAT) |=> cnt == SAT);
endmodule

// File: rtl/cgm_judge.sv
// Classifies each interval, tracks start-up qualification, raises detection
module cgm_judge
  import cgm_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = W + 2,
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          restart,
  input  logic          rise,
  input  logic          seen,
  input  logic [CW-1:0] cnt,
  input  logic [W-1:0]  min_p,
  input  logic [W-1:0]  max_p,
  input  logic [CW-1:0] tmo,
  input  logic [QW-1:0] qual,
  output logic          armed,
  output logic          det,
  output cause_e        det_cause
);
  logic [QW-1:0] run;
  logic          ev, early, slow, bad_ev, good_ev, lost;

  always_comb begin
    ev      = rise && seen;
    early   = cnt < CW'(min_p);
    slow    = cnt > CW'(max_p);
    bad_ev  = ev && (early || slow);
    good_ev = ev && !(early || slow);
    lost    = !rise && (cnt >= tmo);
    det     = en && armed && (bad_ev || lost);
    if (bad_ev)    det_cause = early ? CAUSE_EARLY : CAUSE_SLOW;
    else if (lost) det_cause = CAUSE_LOST;
    else           det_cause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || restart) begin
      run   <= '0;
      armed <= 1'b0;
    end else if (!armed) begin
      if (run >= qual)  armed <= 1'b1;
      else if (good_ev) run   <= run + 1'b1;
      else if (bad_ev)  run   <= '0;
    end
  end

  // a detection always carries a real cause code (R1)
  p_cause_code_r1: assert property (@(posedge clk) disable iff (rst)
    det |-> det_cause != CAUSE_NONE);
  // arming only follows enough good intervals (R7)
  p_arm_after_run_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(run) >= $past(qual));
endmodule

// File: rtl/clk_guard.sv
module clk_guard
  import cgm_pkg::*;
#(
  parameter int W      = 16,
  parameter int QW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk_ref,
  input  logic          rst,
  input  logic          ext_clk,
  input  logic          enable,
  input  logic [W-1:0]  min_period,
  input  logic [W-1:0]  max_period,
  input  logic [W-1:0]  timeout,
  input  logic [QW-1:0] qual_count,
  input  logic          ack,
  output logic          fault,
  output logic [1:0]    cause,
  output logic          reset_req,
  output logic          use_internal
);
  localparam int CW = W + 2;

  logic          rise, seen, armed, det;
  logic [CW-1:0] cnt, eff_tmo;
  cause_e        det_cause;

  assign eff_tmo = (timeout == '0) ? {max_period, 2'b00} : CW'(timeout);

  cgm_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk_ref), .rst(rst), .async_in(ext_clk), .rise_o(rise)
  );

  cgm_meter #(.CW(CW)) u_meter (
    .clk(clk_ref), .rst(rst), .en(enable), .clr(ack), .rise(rise),
    .cnt(cnt), .seen(seen)
  );

  cgm_judge #(.W(W), .CW(CW), .QW(QW)) u_judge (
    .clk(clk_ref), .rst(rst), .en(enable), .restart(ack), .rise(rise),
    .seen(seen), .cnt(cnt), .min_p(min_period), .max_p(max_period),
    .tmo(eff_tmo), .qual(qual_count), .armed(armed), .det(det),
    .det_cause(det_cause)
  );

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      fault        <= 1'b0;
      cause        <= CAUSE_NONE;
      reset_req    <= 1'b0;
      use_internal <= 1'b0;
    end else begin
      reset_req <= 1'b0;
      if (ack) begin
        fault        <= 1'b0;
        cause        <= CAUSE_NONE;
        use_internal <= 1'b0;
      end else if (det && !fault) begin
        fault        <= 1'b1;
        cause        <= det_cause;
        use_internal <= 1'b1;
        reset_req    <= 1'b1;
      end
    end
  end

  p_sticky_r6: assert property (@(posedge clk_ref) disable iff (rst)
    (fault && !ack) |=> fault);
  p_cause_hold_r8: assert property (@(posedge clk_ref) disable iff (rst)
    (fault && !ack) |=> $stable(cause));
  p_select_r4: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(fault) |-> (use_internal && cause != 2'b00));
  p_req_pulse_r5: assert property (@(posedge clk_ref) disable iff (rst)
    reset_req |-> $rose(fault));
  p_req_once_r5: assert property (@(posedge clk_ref) disable iff (rst)
    reset_req |=> !reset_req);
  p_armed_first_r7: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(fault) |-> $past(armed));
  p_idle_clean_r4: assert property (@(posedge clk_ref) disable iff (rst)
    !fault |-> (cause == 2'b00 && !use_internal));
endmodule

// File: tb/clk_guard_test.sv
module clk_guard_test;
  localparam int CLK_P = 10;
  localparam int W = 10;
  localparam int QW = 4;

  logic clk = 1'b0, rst = 1'b1, ext = 1'b0, enable = 1'b0, ack = 1'b0;
  logic [W-1:0] min_p = 10'd8, max_p = 10'd12, tmo = '0;
  logic [QW-1:0] qual = '0;
  logic fault, reset_req, use_internal;
  logic [1:0] cause;
  int checks = 0, fails = 0, rr_cnt = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  clk_guard #(.W(W), .QW(QW)) uut (
    .clk_ref(clk), .rst(rst), .ext_clk(ext), .enable(enable),
    .min_period(min_p), .max_period(max_p), .timeout(tmo),
    .qual_count(qual), .ack(ack), .fault(fault), .cause(cause),
    .reset_req(reset_req), .use_internal(use_internal)
  );

  always @(negedge clk) if (!rst && reset_req) rr_cnt++;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // rising edge now, then the next rising edge exactly g ticks later
  task automatic pulse(int g);
    ext = 1'b1;
    @(negedge clk);
    ext = 1'b0;
    repeat (g - 1) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    ext = 1'b0;
    enable = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    enable = 1'b1;
    @(negedge clk);
  endtask

  function automatic int exp_cause(int g, int mn, int mx);
    if (g < mn) return 1;
    if (g > mx) return 2;
    return 0;
  endfunction

  task automatic chk_state(string tag, int f, int c);
    chk({tag, " fault"}, int'(fault), f);
    chk({tag, " cause"}, int'(cause), c);
    chk({tag, " select"}, int'(use_internal), f);
  endtask

  initial begin
    int rr0;
    void'($urandom(32'd4242));
    idle(5);
    rst = 1'b0;
    idle(1);
    // R10 reset state
    chk_state("R10 reset", 0, 0);
    chk("R10 reset_req", int'(reset_req), 0);

    // R7: start-up masking with early intervals
    qual = 4'd4; tmo = '0;
    enable = 1'b1;
    for (int i = 0; i < 10; i++) pulse(3);
    chk_state("R7 unarmed early edges", 0, 0);
    for (int i = 0; i < 6; i++) pulse(10);
    chk_state("R7 good intervals", 0, 0);
    // R1 early glitch, R4 select, R5 pulse
    rr0 = rr_cnt;
    pulse(3); pulse(10);
    chk_state("R1 early edge", 1, 1);
    chk("R5 one reset_req", rr_cnt - rr0, 1);

    // R6 sticky, R8 cause held
    for (int i = 0; i < 5; i++) pulse(10);
    chk_state("R6 sticky under good clock", 1, 1);
    pulse(20); pulse(10);
    chk_state("R8 later slow ignored", 1, 1);
    chk("R8 no extra reset_req", rr_cnt - rr0, 1);

    // R9 fault retained while disabled
    enable = 1'b0;
    idle(20);
    chk_state("R9 held while disabled", 1, 1);

    // R6 ack clears and restarts qualification
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk_state("R6 ack clears", 0, 0);
    enable = 1'b1;
    pulse(10); pulse(3); pulse(10);
    chk_state("R6 requalify after ack", 0, 0);

    // R9 no detection while disabled
    qual = '0;
    restart();
    enable = 1'b0;
    for (int i = 0; i < 4; i++) begin pulse(10); pulse(3); end
    chk_state("R9 disabled glitches", 0, 0);
    enable = 1'b1;

    // R2 boundaries
    restart();
    pulse(8); pulse(12); pulse(8); pulse(12); pulse(8);
    chk_state("R2 min and max accepted", 0, 0);
    rr0 = rr_cnt;
    pulse(13); pulse(10);
    chk_state("R2 max plus one slow", 1, 2);
    chk("R5 slow reset_req", rr_cnt - rr0, 1);
    restart();
    pulse(10); pulse(10); pulse(7); pulse(10);
    chk_state("R1 min minus one early", 1, 1);

    // R3 default timeout = 4 x max = 48
    restart();
    for (int i = 0; i < 4; i++) pulse(10);
    idle(30);
    chk_state("R3 default before timeout", 0, 0);
    idle(20);
    chk_state("R3 default lost", 1, 3);

    // R3 programmed timeout 20
    tmo = 10'd20;
    restart();
    for (int i = 0; i < 3; i++) pulse(10);
    idle(5);
    chk_state("R3 programmed before timeout", 0, 0);
    idle(17);
    chk_state("R3 programmed lost", 1, 3);
    tmo = '0;

    // random limits and gaps against bench classification (R1 R2)
    for (int it = 0; it < 40; it++) begin
      int mn, mx, g, e;
      mn = 4 + int'($urandom_range(6));
      mx = mn + int'($urandom_range(8));
      g  = 2 + int'($urandom_range(mx + 4));
      min_p = W'(mn); max_p = W'(mx);
      restart();
      for (int k = 0; k < 3; k++) pulse(mn + int'($urandom_range(mx - mn)));
      pulse(g); pulse(mx);
      e = exp_cause(g, mn, mx);
      chk_state($sformatf("R1/R2 random gap %0d min %0d max %0d", g, mn, mx),
                (e != 0) ? 1 : 0, e);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule